// File: doc/BRIEF.md
# Serial-to-Vector Element Collector

The collector assembles a vector of `NUM_ELEM` scalar elements that arrive one at a time. An external sequencer presents one element on `din` together with a step number on `step_idx` and raises `en`. On that clock edge the collector stores the element in the slot chosen by the step number. Counting, sequencing and any handshake belong to that sequencer and are not part of this block.

Only `NUM_ELEM-1` slots are stored. The element with the highest step number is never stored. It flows combinationally from `din` into the top slice of `vec_out`. As a result, during the final step `vec_out` already shows the whole vector, and no register is spent on the last element. The output vector is a plain concatenation of the stored slots and the live input, with no logic in between.

Top module: `vec_gather`

## Requirements
- R1: When `rst` is high at a rising edge of `clk`, every stored slot is cleared to zero, whatever `en` and `step_idx` are. The stored slots are the lower `NUM_ELEM-1` slices of `vec_out`.
- R2: The top slice of `vec_out` (bits `NUM_ELEM*ELEM_W-1` down to `(NUM_ELEM-1)*ELEM_W`) equals `din` at all times, with no clock delay.
- R3: On a rising edge with `en` high and `step_idx` = k, where 0 <= k <= `NUM_ELEM-2`, slot k takes the value of `din`. Slot k is `vec_out` bits `k*ELEM_W` upward. The new value is visible after that edge.
- R4: On any edge at most one stored slot changes. A slot whose index differs from `step_idx` keeps its value.
- R5: While `en` is low at a rising edge, all stored slots keep their values.
- R6: A step with `step_idx` = `NUM_ELEM-1` writes no stored slot.
- R7: A step with `step_idx` >= `NUM_ELEM` writes no stored slot.
- R8: After reset, `NUM_ELEM` enabled steps with indices 0, 1, ..., `NUM_ELEM-1` place element 0 in the least significant slice. During the final step, `vec_out` holds all `NUM_ELEM` elements in step order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; slots load on its rising edge |
| rst | input | 1 | Synchronous active-high clear of all stored slots |
| en | input | 1 | Step strobe from the sequencer |
| step_idx | input | SEL_W | Step number selecting the slot to load |
| din | input | ELEM_W | Incoming element |
| vec_out | output | NUM_ELEM*ELEM_W | Assembled vector; element 0 in the low slice |

## Verification
The top slice is combinational, so the bench checks it 1 ns after driving `din` and before any clock edge (R2, and the full vector for R8). Slot writes take effect at the next rising edge. The bench therefore compares the stored slices with its own slot model 1 ns after that edge. This is one register stage, and the inputs for the next step are not yet driven at that point. Hold, ignored-index and reset cases are checked at the same point: the bench compares every stored slice against the unchanged model.

// File: rtl/vg_pkg.sv
package vg_pkg;

   // Width of the step number: one bit wider than needed, so that
   // indices beyond the last element can be presented.
   function automatic int sel_width(input int n_elem);
      return $clog2(n_elem) + 1;
   endfunction

   // Number of stored slots for a vector of n_elem elements.
   function automatic int store_slots(input int n_elem);
      return n_elem - 1;
   endfunction

endpackage

// File: rtl/vg_step_decode.sv
module vg_step_decode #(
   parameter int NUM_SLOT = 3,
   parameter int SEL_W    = 3
) (
   input  logic                en,
   input  logic [SEL_W-1:0]    step_idx,
   output logic [NUM_SLOT-1:0] wr_en
);

   // One strobe per stored slot. Indices with no slot decode to nothing.
   for (genvar k = 0; k < NUM_SLOT; k++) begin : g_dec
      assign wr_en[k] = en && (step_idx == SEL_W'(k));
   end

endmodule

// File: rtl/vg_elem_bank.sv
module vg_elem_bank #(
   parameter int NUM_SLOT = 3,
   parameter int ELEM_W   = 8,
   localparam int BANK_W  = NUM_SLOT * ELEM_W
) (
   input  logic                clk,
   input  logic                rst,
   input  logic [NUM_SLOT-1:0] wr_en,
   input  logic [ELEM_W-1:0]   din,
   output logic [BANK_W-1:0]   q
);

   for (genvar k = 0; k < NUM_SLOT; k++) begin : g_slot
      logic [ELEM_W-1:0] slot_q;

      always_ff @(posedge clk) begin
         if (rst)
            slot_q <= '0;
         else if (wr_en[k])
            slot_q <= din;
      end

      assign q[k*ELEM_W +: ELEM_W] = slot_q;
   end

endmodule

// File: rtl/vg_concat.sv
module vg_concat #(
   parameter int NUM_ELEM = 4,
   parameter int ELEM_W   = 8,
   localparam int STORE_W = (NUM_ELEM - 1) * ELEM_W,
   localparam int VEC_W   = NUM_ELEM * ELEM_W
) (
   input  logic [STORE_W-1:0] stored,
   input  logic [ELEM_W-1:0]  live,
   output logic [VEC_W-1:0]   vec
);

   for (genvar k = 0; k < NUM_ELEM - 1; k++) begin : g_low
      assign vec[k*ELEM_W +: ELEM_W] = stored[k*ELEM_W +: ELEM_W];
   end
   assign vec[VEC_W-1 -: ELEM_W] = live;

endmodule

// File: rtl/vec_gather.sv
module vec_gather #(
   parameter int ELEM_W   = 8,
   parameter int NUM_ELEM = 4,
   parameter int SEL_W    = vg_pkg::sel_width(NUM_ELEM),
   localparam int NUM_SLOT = vg_pkg::store_slots(NUM_ELEM),
   localparam int STORE_W  = NUM_SLOT * ELEM_W,
   localparam int VEC_W    = NUM_ELEM * ELEM_W
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              en,
   input  logic [SEL_W-1:0]  step_idx,
   input  logic [ELEM_W-1:0] din,
   output logic [VEC_W-1:0]  vec_out
);

   if (NUM_ELEM < 2) begin : g_chk_elem
      $error("vec_gather: NUM_ELEM must be at least 2");
   end
   if (ELEM_W < 1) begin : g_chk_width
      $error("vec_gather: ELEM_W must be at least 1");
   end
   if (SEL_W < $clog2(NUM_ELEM)) begin : g_chk_sel
      $error("vec_gather: SEL_W too narrow for NUM_ELEM");
   end

   logic [NUM_SLOT-1:0] wr_en;
   logic [STORE_W-1:0]  stored;

   vg_step_decode #(.NUM_SLOT(NUM_SLOT), .SEL_W(SEL_W)) u_decode (
      .en       (en),
      .step_idx (step_idx),
      .wr_en    (wr_en)
   );

   vg_elem_bank #(.NUM_SLOT(NUM_SLOT), .ELEM_W(ELEM_W)) u_bank (
      .clk   (clk),
      .rst   (rst),
      .wr_en (wr_en),
      .din   (din),
      .q     (stored)
   );

   vg_concat #(.NUM_ELEM(NUM_ELEM), .ELEM_W(ELEM_W)) u_concat (
      .stored (stored),
      .live   (din),
      .vec    (vec_out)
   );

endmodule

// File: rtl/vg_checker.sv
module vg_checker #(
   parameter int ELEM_W   = 8,
   parameter int NUM_ELEM = 4,
   parameter int SEL_W    = 3,
   localparam int STORE_W = (NUM_ELEM - 1) * ELEM_W,
   localparam int VEC_W   = NUM_ELEM * ELEM_W
) (
   input logic              clk,
   input logic              rst,
   input logic              en,
   input logic [SEL_W-1:0]  step_idx,
   input logic [ELEM_W-1:0] din,
   input logic [VEC_W-1:0]  vec_out
);

   // R1: reset clears every stored slot
   a_r1_reset_clears: assert property (@(posedge clk)
      rst |=> vec_out[STORE_W-1:0] == '0);

   // R2: top slice follows the live input
   a_r2_live_top: assert property (@(posedge clk) disable iff (rst)
      vec_out[VEC_W-1 -: ELEM_W] == din);

   // R5: no strobe, no change
   a_r5_hold_idle: assert property (@(posedge clk) disable iff (rst)
      !en |=> $stable(vec_out[STORE_W-1:0]));

   // R6, R7: the last index and indices beyond it store nothing
   a_r6_r7_no_slot: assert property (@(posedge clk) disable iff (rst)
      (en && step_idx >= SEL_W'(NUM_ELEM - 1)) |=> $stable(vec_out[STORE_W-1:0]));

   for (genvar k = 0; k < NUM_ELEM - 1; k++) begin : g_slot_chk
      // R3: selected slot loads din
      a_r3_load: assert property (@(posedge clk) disable iff (rst)
         (en && step_idx == SEL_W'(k)) |=> vec_out[k*ELEM_W +: ELEM_W] == $past(din));
      // R4: unselected slots keep their value
      a_r4_others_hold: assert property (@(posedge clk) disable iff (rst)
         (step_idx != SEL_W'(k)) |=> $stable(vec_out[k*ELEM_W +: ELEM_W]));
   end

endmodule

bind vec_gather vg_checker #(
   .ELEM_W(ELEM_W), .NUM_ELEM(NUM_ELEM), .SEL_W(SEL_W)
) u_vg_checker (
   .clk(clk), .rst(rst), .en(en), .step_idx(step_idx), .din(din), .vec_out(vec_out)
);

// File: tb/vec_gather_bench.sv
`timescale 1ns/1ps
module vec_gather_bench;

   localparam int ELEM_W   = 8;
   localparam int NUM_ELEM = 4;
   localparam int SEL_W    = vg_pkg::sel_width(NUM_ELEM);
   localparam int STORE_W  = (NUM_ELEM - 1) * ELEM_W;
   localparam int VEC_W    = NUM_ELEM * ELEM_W;

   logic              clk = 1'b0;
   logic              rst = 1'b1;
   logic              en  = 1'b0;
   logic [SEL_W-1:0]  step_idx = '0;
   logic [ELEM_W-1:0] din = '0;
   logic [VEC_W-1:0]  vec_out;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;
   logic [STORE_W-1:0] model = '0;

   always #5 clk = ~clk;

   vec_gather #(.ELEM_W(ELEM_W), .NUM_ELEM(NUM_ELEM)) u_vec_gather (
      .clk(clk), .rst(rst), .en(en), .step_idx(step_idx), .din(din), .vec_out(vec_out)
   );

   task automatic check(input string tag, input logic [VEC_W-1:0] act,
                        input logic [VEC_W-1:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   // Expected stored slots after one edge, from the requirements.
   function automatic logic [STORE_W-1:0] next_store(input logic [STORE_W-1:0] cur,
      input logic r, input logic e, input int idx, input logic [ELEM_W-1:0] d);
      logic [STORE_W-1:0] n = cur;
      if (r) n = '0;
      else if (e && idx < NUM_ELEM - 1) n[idx*ELEM_W +: ELEM_W] = d;
      return n;
   endfunction

   function automatic string tag_of(input logic r, input logic e, input int idx);
      if (r) return "R1 reset";
      if (!e) return "R5 idle hold";
      if (idx == NUM_ELEM - 1) return "R6 last index";
      if (idx >= NUM_ELEM) return "R7 out of range";
      return "R3/R4 slot load";
   endfunction

   // Called just after a negative edge: drive, check live slice, clock, check slots.
   task automatic step(input logic r, input logic e, input int idx, input logic [ELEM_W-1:0] d);
      rst = r; en = e; step_idx = SEL_W'(idx); din = d;
      #1;
      check("R2 live top slice", VEC_W'(vec_out[VEC_W-1 -: ELEM_W]), VEC_W'(d));
      @(posedge clk);
      model = next_store(model, r, e, idx, d);
      #1;
      check(tag_of(r, e, idx), VEC_W'(vec_out[STORE_W-1:0]), VEC_W'(model));
      @(negedge clk);
   endtask

   initial begin
      logic [VEC_W-1:0] full_exp;
      void'($urandom(32'd2024));
      @(negedge clk);
      // R1: reset with a strobe present still clears
      step(1'b1, 1'b1, 0, 8'hAA);
      step(1'b1, 1'b0, 0, 8'h00);

      // R8: ordered fill, full vector during the final step
      for (int k = 0; k < NUM_ELEM - 1; k++) step(1'b0, 1'b1, k, 8'h11 * (k + 1));
      rst = 1'b0; en = 1'b1; step_idx = SEL_W'(NUM_ELEM - 1); din = 8'h44;
      #1;
      for (int k = 0; k < NUM_ELEM; k++) full_exp[k*ELEM_W +: ELEM_W] = 8'(8'h11 * (k + 1));
      check("R8 full vector", vec_out, full_exp);
      @(negedge clk);
      step(1'b0, 1'b1, NUM_ELEM - 1, 8'h55);   // R6
      step(1'b0, 1'b1, NUM_ELEM, 8'h66);       // R7
      step(1'b0, 1'b1, (1 << SEL_W) - 1, 8'h77); // R7
      step(1'b0, 1'b0, 1, 8'h88);              // R5
      step(1'b0, 1'b1, 0, 8'hFF);              // R3, R4
      step(1'b0, 1'b1, NUM_ELEM - 2, 8'h00);   // R3, R4

      // Constrained random mix
      for (int i = 0; i < 400; i++) begin
         logic r = ($urandom % 32) == 0;
         logic e = ($urandom % 10) < 7;
         int   idx = int'($urandom % (1 << SEL_W));
         step(r, e, idx, 8'($urandom));
      end

      if (!done) begin
         done = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

endmodule